// File: doc/BRIEF.md
# Aspect-Signalling Control Port (I2C Target)

This block is the register access port of a widescreen aspect-signalling codec. It answers as an I2C target at 7-bit address 0x40 (standard mode). It holds the settings and the words that the inserter puts on the video signal, and it returns the most recent decoded identification word to the bus master.

A write transaction carries a subaddress byte first. That byte picks the first of three writable bytes. Each data byte lands at the current index, and the index then steps forward, so the master can refresh any tail of the set without touching the bytes before it. A read transaction has no subaddress. It always returns the same two-byte frame built from the decoder outputs. That frame is frozen when the address is acknowledged.

The block drives SDA only by pulling it low through an output enable. It never stretches the clock and takes no part in arbitration. Both bus lines are brought into the system clock domain through two-flop synchronizers. START and STOP are detected as SDA edges while SCL is high.

Top module: `aspect_i2c_slave`

## Requirements
- R1: An address byte of 0x40 with either direction bit is acknowledged (SDA low in the ninth clock). Any other address is not acknowledged, and the rest of that transaction has no effect on any output.
- R2: In a write, the byte after the address is a subaddress giving the index (0, 1 or 2) of the first byte to store. Bytes at lower indices keep their values. Register outputs change only when a data byte is stored.
- R3: After each stored data byte the index steps by one. Data bytes sent after index 2 has been written are acknowledged and discarded.
- R4: A subaddress above 2 is acknowledged, and every data byte that follows it in that transaction is acknowledged and discarded.
- R5: Byte 0 sets the settings: bit 7 selects decode input 2, bit 6 is run (1) / reset (0), bit 5 enables insertion, bit 4 is the test bit, and bit 3 widens the line range; bits 2:0 are dropped. Byte 1 bits 5:0 set the inserted word0, and bits 7:6 are dropped. Byte 2 bits 7:4 set word1 and bits 3:0 set word2.
- R6: A read returns byte A = {word1[3:0], word2[3:0]} and then byte B = {word0[5:0], crc_ok, valid}. Any further byte the master acknowledges reads as 0xFF. A master NACK ends the transfer.
- R7: Both read bytes come from the decoder inputs as they stood when the read address was acknowledged. Later changes to those inputs do not alter the bytes of that transfer.
- R8: A STOP or a repeated START abandons any byte in progress without storing it and releases SDA. A repeated START begins a fresh address phase.
- R9: After reset, all settings and inserted words are 0 and SDA is released.
- R10: The block changes SDA only while SCL is low. Its output enable never rises while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| dec_word0 | input | 6 | Decoded word0 |
| dec_word1 | input | 4 | Decoded word1 |
| dec_word2 | input | 4 | Decoded word2 |
| dec_crc_ok | input | 1 | Decoded CRC check passed |
| dec_valid | input | 1 | Decoded data judged valid |
| cfg_chan2 | output | 1 | Decode input 2 selected |
| cfg_run | output | 1 | Core running (0 holds it in reset) |
| cfg_insert | output | 1 | Insertion enabled |
| cfg_test | output | 1 | Test bit |
| cfg_wide | output | 1 | Decode one extra line each side |
| ins_word0 | output | 6 | word0 to insert |
| ins_word1 | output | 4 | word1 to insert |
| ins_word2 | output | 4 | word2 to insert |

## Verification
The bench targets the subaddress corners: a start at index 2, a burst that runs past index 2, and an out-of-range subaddress. A design that fails to saturate the index would wrap around and corrupt byte 0. A design that fails to guard the index would lose the acknowledge or write a stray byte. The bench also changes the decoder inputs between the two read bytes, where a design that fetches each byte on demand would return a mixed frame. It then cuts a data byte short with a STOP and with a repeated START. A design that keys storage on its bit counter alone would store a half-shifted byte there, and one that fails to restart would miss the next address.

// File: rtl/aspi_pkg.sv
package aspi_pkg;

    localparam int          BYTE_W     = 8;
    localparam logic [6:0]  SLAVE_ADDR = 7'h40;
    localparam int          NUM_WR     = 3;
    localparam int          IDX_W      = $clog2(NUM_WR + 1);
    localparam logic [IDX_W-1:0] IDX_DEAD = IDX_W'(NUM_WR);
    localparam int          CNT_W      = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_SUB,
        S_WDATA,
        S_ACK,
        S_RDATA,
        S_RACK
    } bus_state_t;

    typedef struct packed {
        logic chan2;
        logic run;
        logic insert;
        logic test;
        logic wide;
    } settings_t;

    function automatic logic [BYTE_W-1:0] frame_a(input logic [3:0] w1, input logic [3:0] w2);
        return {w1, w2};
    endfunction

    function automatic logic [BYTE_W-1:0] frame_b(input logic [5:0] w0, input logic crc, input logic vld);
        return {w0, crc, vld};
    endfunction

    function automatic logic [IDX_W-1:0] sub_to_idx(input logic [BYTE_W-1:0] sub);
        return (sub >= BYTE_W'(NUM_WR)) ? IDX_DEAD : sub[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/aspi_line_cond.sv
module aspi_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] chain [SYNC_STAGES];
    logic [NLINES-1:0] prev;
    logic [NLINES-1:0] cur;

    assign raw = {scl_i, sda_i};

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '1;
                else if (s == 0) chain[s] <= raw;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign cur = chain[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= cur;
    end

    assign sda_s     = cur[0];
    assign scl_rise  =  cur[1] & ~prev[1];
    assign scl_fall  = ~cur[1] &  prev[1];
    assign start_evt =  cur[1] &  prev[1] &  prev[0] & ~cur[0];
    assign stop_evt  =  cur[1] &  prev[1] & ~prev[0] &  cur[0];

endmodule

// File: rtl/aspi_regfile.sv
module aspi_regfile
    import aspi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [BYTE_W-1:0]    wr_data,
    output settings_t            set_q,
    output logic [5:0]           w0_q,
    output logic [BYTE_W-1:0]    w12_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            set_q <= '0;
            w0_q  <= '0;
            w12_q <= '0;
        end else if (wr_en) begin
            case (wr_idx)
                IDX_W'(0): set_q <= settings_t'(wr_data[7:3]);
                IDX_W'(1): w0_q  <= wr_data[5:0];
                IDX_W'(2): w12_q <= wr_data;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/aspect_i2c_slave.sv
module aspect_i2c_slave
    import aspi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [5:0] dec_word0,
    input  logic [3:0] dec_word1,
    input  logic [3:0] dec_word2,
    input  logic       dec_crc_ok,
    input  logic       dec_valid,
    output logic       cfg_chan2,
    output logic       cfg_run,
    output logic       cfg_insert,
    output logic       cfg_test,
    output logic       cfg_wide,
    output logic [5:0] ins_word0,
    output logic [3:0] ins_word1,
    output logic [3:0] ins_word2
);
    logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;

    aspi_line_cond #(.SYNC_STAGES(2)) u_line (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    bus_state_t          state, ret;
    logic [CNT_W-1:0]    cnt;
    logic [BYTE_W-1:0]   sh, tx, snap_a, snap_b, next_b;
    logic [IDX_W-1:0]    ptr;
    logic [1:0]          rd_idx;
    logic                mack;
    logic                byte_done, wr_en;
    settings_t           set_q;
    logic [5:0]          w0_q;
    logic [BYTE_W-1:0]   w12_q;

    assign byte_done = scl_fall && (cnt == CNT_FULL) && !start_evt && !stop_evt;
    assign wr_en     = byte_done && (state == S_WDATA) && (ptr != IDX_DEAD);

    always_comb begin
        case (rd_idx)
            2'd1:    next_b = snap_b;
            default: next_b = '1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            ret    <= S_IDLE;
            cnt    <= '0;
            sh     <= '0;
            tx     <= '1;
            snap_a <= '0;
            snap_b <= '0;
            ptr    <= '0;
            rd_idx <= '0;
            mack   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (start_evt) begin
            state  <= S_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (stop_evt) begin
            state  <= S_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                S_ADDR, S_SUB, S_WDATA: begin
                    if (scl_rise) begin
                        sh  <= {sh[BYTE_W-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end else if (byte_done) begin
                        sda_oe <= 1'b1;
                        state  <= S_ACK;
                        if (state == S_ADDR) begin
                            if (sh[7:1] != SLAVE_ADDR) begin
                                sda_oe <= 1'b0;
                                state  <= S_IDLE;
                            end else if (sh[0]) begin
                                ret    <= S_RDATA;
                                snap_a <= frame_a(dec_word1, dec_word2);
                                snap_b <= frame_b(dec_word0, dec_crc_ok, dec_valid);
                            end else begin
                                ret <= S_SUB;
                            end
                        end else if (state == S_SUB) begin
                            ptr <= sub_to_idx(sh);
                            ret <= S_WDATA;
                        end else begin
                            if (ptr != IDX_DEAD) ptr <= ptr + 1'b1;
                            ret <= S_WDATA;
                        end
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        cnt   <= '0;
                        state <= ret;
                        if (ret == S_RDATA) begin
                            tx     <= snap_a;
                            sda_oe <= ~snap_a[BYTE_W-1];
                            rd_idx <= 2'd1;
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                S_RDATA: begin
                    if (scl_rise) begin
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (cnt == CNT_FULL) begin
                            sda_oe <= 1'b0;
                            state  <= S_RACK;
                        end else begin
                            sda_oe <= ~tx[BYTE_W-2];
                            tx     <= {tx[BYTE_W-2:0], 1'b1};
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (mack) begin
                            tx     <= next_b;
                            sda_oe <= ~next_b[BYTE_W-1];
                            cnt    <= '0;
                            state  <= S_RDATA;
                            if (rd_idx != 2'd2) rd_idx <= rd_idx + 1'b1;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    aspi_regfile u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(ptr), .wr_data(sh),
        .set_q(set_q), .w0_q(w0_q), .w12_q(w12_q)
    );

    assign cfg_chan2  = set_q.chan2;
    assign cfg_run    = set_q.run;
    assign cfg_insert = set_q.insert;
    assign cfg_test   = set_q.test;
    assign cfg_wide   = set_q.wide;
    assign ins_word0  = w0_q;
    assign ins_word1  = w12_q[7:4];
    assign ins_word2  = w12_q[3:0];

endmodule

// File: rtl/aspi_checker.sv
module aspi_checker (
    input logic        clk,
    input logic        rst,
    input logic        scl_i,
    input logic        sda_oe,
    input logic        start_evt,
    input logic        stop_evt,
    input logic        wr_en,
    input logic [18:0] regimg
);
    a_r9_released_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !sda_oe);

    a_r8_stop_releases: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !sda_oe);

    a_r8_start_releases: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> !sda_oe);

    a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_i);

    a_r2_regs_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regimg));
endmodule

bind aspect_i2c_slave aspi_checker u_chk (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
    .start_evt(start_evt), .stop_evt(stop_evt), .wr_en(wr_en),
    .regimg({cfg_chan2, cfg_run, cfg_insert, cfg_test, cfg_wide,
             ins_word0, ins_word1, ins_word2})
);

// File: tb/aspect_i2c_slave_tb.sv
`timescale 1ns/1ps
module aspect_i2c_slave_tb;
    localparam int H     = 16;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, sda_line;
    logic [5:0] dw0 = '0;
    logic [3:0] dw1 = '0, dw2 = '0;
    logic dcrc = 1'b0, dvld = 1'b0;
    logic c_ch, c_run, c_ins, c_tst, c_wide;
    logic [5:0] o_w0;
    logic [3:0] o_w1, o_w2;

    int checks = 0, fails = 0, cyc = 0;
    logic quiet = 1'b0;
    logic [7:0] exp_b [3];

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    aspect_i2c_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .dec_word0(dw0), .dec_word1(dw1), .dec_word2(dw2),
        .dec_crc_ok(dcrc), .dec_valid(dvld),
        .cfg_chan2(c_ch), .cfg_run(c_run), .cfg_insert(c_ins), .cfg_test(c_tst),
        .cfg_wide(c_wide), .ins_word0(o_w0), .ins_word1(o_w1), .ins_word2(o_w2)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_img();
        return {exp_b[0][7:3], exp_b[1][5:0], exp_b[2]};
    endfunction

    // R5 field positions / R2 hold: register image compared on every quiet clock
    always @(negedge clk) begin
        if (quiet) begin
            chk("R5 register image", int'({c_ch, c_run, c_ins, c_tst, c_wide, o_w0, o_w1, o_w2}), exp_img());
            chk("R10 idle release", int'(sda_oe), 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == LIMIT) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(4);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H/2); b = sda_line; wt(H/2); scl_m = 1'b0; wt(4);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) bit_in(d[i]);
        bit_out(~mack);
    endtask

    // behavioural write transaction with model update
    task automatic do_write(input logic [6:0] addr, input logic [7:0] sub, input logic [7:0] q[$]);
        logic ack;
        int idx;
        quiet = 1'b0;
        bus_start();
        wr_byte({addr, 1'b0}, ack);
        chk("R1 address ack", int'(ack), int'(addr == 7'h40));
        if (ack) begin
            wr_byte(sub, ack);
            chk("R4 subaddress ack", int'(ack), 1);
            idx = int'(sub);
            foreach (q[k]) begin
                wr_byte(q[k], ack);
                chk("R3 data ack", int'(ack), 1);
                if (idx <= 2) exp_b[idx] = q[k];
                if (idx < 3) idx++;
            end
        end
        bus_stop();
        wt(8);
        quiet = 1'b1;
    endtask

    initial begin
        logic ack;
        logic [7:0] d;
        exp_b[0] = 8'h00; exp_b[1] = 8'h00; exp_b[2] = 8'h00;
        wt(5);
        chk("R9 sda released in reset", int'(sda_oe), 0);
        rst = 1'b0;
        wt(4);
        chk("R9 reset outputs", int'({c_ch, c_run, c_ins, c_tst, c_wide, o_w0, o_w1, o_w2}), 0);
        quiet = 1'b1;

        // R2 R5: full write from index 0
        do_write(7'h40, 8'd0, '{8'hCF, 8'hEA, 8'h96});
        chk("R5 chan2/run/insert/test/wide", int'({c_ch, c_run, c_ins, c_tst, c_wide}), 5'b11001);
        chk("R5 word0 drops bits 7:6", int'(o_w0), 6'h2A);
        chk("R5 word1/word2", int'({o_w1, o_w2}), 8'h96);

        // R2: start at index 2 only
        do_write(7'h40, 8'd2, '{8'h3C});
        chk("R2 byte0 kept", int'({c_ch, c_run, c_ins, c_tst, c_wide}), 5'b11001);
        chk("R2 byte2 stored", int'({o_w1, o_w2}), 8'h3C);

        // R3: burst past index 2
        do_write(7'h40, 8'd1, '{8'h15, 8'hA7, 8'h00, 8'hFF});
        chk("R3 byte0 not wrapped", int'({c_ch, c_run, c_ins, c_tst, c_wide}), 5'b11001);
        chk("R3 last stored byte2", int'({o_w1, o_w2}), 8'hA7);

        // R4: out-of-range subaddress
        do_write(7'h40, 8'd5, '{8'h00, 8'h00});
        chk("R4 no change", int'(o_w0), 6'h15);

        // R1: foreign address
        do_write(7'h41, 8'd0, '{8'h00});
        chk("R1 foreign address ignored", int'({o_w1, o_w2}), 8'hA7);

        // R6: read frame
        dw0 = 6'h2D; dw1 = 4'hA; dw2 = 4'h5; dcrc = 1'b1; dvld = 1'b0;
        quiet = 1'b0;
        bus_start();
        wr_byte({7'h40, 1'b1}, ack);
        chk("R1 read address ack", int'(ack), 1);
        rd_byte(1'b1, d); chk("R6 byte A", int'(d), 8'hA5);
        rd_byte(1'b1, d); chk("R6 byte B", int'(d), 8'hB6);
        rd_byte(1'b0, d); chk("R6 extra byte", int'(d), 8'hFF);
        bus_stop(); wt(8); quiet = 1'b1;

        // R7: snapshot at address ack
        quiet = 1'b0;
        bus_start();
        wr_byte({7'h40, 1'b1}, ack);
        dw0 = 6'h13; dw1 = 4'h1; dw2 = 4'h2; dcrc = 1'b0; dvld = 1'b1;
        rd_byte(1'b1, d); chk("R7 byte A frozen", int'(d), 8'hA5);
        rd_byte(1'b0, d); chk("R7 byte B frozen", int'(d), 8'hB6);
        bus_stop(); wt(8);
        bus_start();
        wr_byte({7'h40, 1'b1}, ack);
        rd_byte(1'b1, d); chk("R7 new snapshot A", int'(d), 8'h12);
        rd_byte(1'b0, d); chk("R7 new snapshot B", int'(d), 8'h4D);
        bus_stop(); wt(8); quiet = 1'b1;

        // R8: STOP inside a data byte
        quiet = 1'b0;
        bus_start();
        wr_byte({7'h40, 1'b0}, ack);
        wr_byte(8'd1, ack);
        for (int i = 0; i < 5; i++) bit_out(1'b0);
        bus_stop(); wt(8); quiet = 1'b1;
        chk("R8 stop discards partial byte", int'(o_w0), 6'h15);

        // R8: repeated START inside a data byte, then fresh write
        quiet = 1'b0;
        bus_start();
        wr_byte({7'h40, 1'b0}, ack);
        wr_byte(8'd0, ack);
        for (int i = 0; i < 3; i++) bit_out(1'b0);
        bus_start();
        wr_byte({7'h40, 1'b0}, ack);
        chk("R8 repeated start address ack", int'(ack), 1);
        wr_byte(8'd2, ack);
        wr_byte(8'h5E, ack);
        exp_b[2] = 8'h5E;
        bus_stop(); wt(8); quiet = 1'b1;
        chk("R8 byte0 untouched", int'({c_ch, c_run, c_ins, c_tst, c_wide}), 5'b11001);
        chk("R8 byte2 after restart", int'({o_w1, o_w2}), 8'h5E);

        wt(20);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule